// File: doc/BRIEF.md
# Saturating Cycle-Count Interrupt Timer

This block counts processor cycles in a 15-bit register and requests an interrupt when the count climbs to its ceiling of 0x7FFF. It does not wrap: once at the ceiling it stays there until software reloads it. Software loads and inspects the count through two 2 KiB windows on an 8-bit processor bus. The low window carries count bits 7:0. The high window carries count bits 14:8 together with an interrupt enable in data bit 7.

A pending request is cleared by any read or write that lands in either window. Software typically writes a start value so that the ceiling is reached after the wanted number of cycles, sets the enable, and reads a window in its handler to acknowledge. A request is raised only on the tick that carries the count from 0x7FFE to 0x7FFF. It is therefore not raised again while the count rests at the ceiling.

Top module: `cyc_irq_timer`

## Requirements
- R1: After reset the count is 0x0000, the enable reads as 0 and `irq` is low.
- R2: A write to 0x5000–0x57FF loads count bits 7:0 from the data and leaves bits 14:8 and the enable unchanged.
- R3: A write to 0x5800–0x5FFF loads count bits 14:8 from data bits 6:0 and the enable from data bit 7, leaving count bits 7:0 unchanged.
- R4: While `bus_rd` is high, `bus_rdata` shows count bits 7:0 for the low window, and {enable, count bits 14:8} for the high window, in the same cycle.
- R5: Each clock with `cyc_tick` high, no window write and a count below 0x7FFF adds one to the count, with carry across the two halves.
- R6: At 0x7FFF further ticks leave the count at 0x7FFF.
- R7: When a tick takes the count from 0x7FFE to 0x7FFF with the enable set, `irq` is high from the next clock edge. With the enable clear it stays low.
- R8: `irq` stays high until a read or write in either window. It is low after the clock edge that samples that access.
- R9: A window write and a tick in the same clock: the written value wins and the tick is lost.
- R10: Accesses outside both windows change nothing, do not acknowledge, and read as 0x00.
- R11: While the count rests at 0x7FFF, further ticks after an acknowledge raise no new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Processor bus address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_rdata | output | 8 | Read data, combinational from address and state |
| cyc_tick | input | 1 | One processor cycle elapsed |
| irq | output | 1 | Interrupt request, active high |

## Verification
Read data is combinational from registered state. The bench therefore compares `bus_rdata` in the same cycle the strobe is driven, after the inputs have settled at the falling edge. Writes and ticks are registered once, so their effect is checked at the falling edge that follows the rising edge that took them. `irq` is a single register behind the tick that reaches the ceiling, and it is sampled one edge after that tick. Acknowledge is checked one edge after the access strobe. The driver queues each expectation at exactly that point, and the monitor compares against the ports as it dequeues.

// File: rtl/cit_pkg.sv
package cit_pkg;
  // decoded bus access, one flag per window and direction
  typedef struct packed {
    logic rd_lo;
    logic rd_hi;
    logic wr_lo;
    logic wr_hi;
  } cit_acc_t;

  function automatic logic any_access(input cit_acc_t a);
    return a.rd_lo | a.rd_hi | a.wr_lo | a.wr_hi;
  endfunction
endpackage

// File: rtl/cit_decode.sv
module cit_decode #(
  parameter int ADDR_W    = 16,
  parameter int SPAN_BITS = 11,
  parameter logic [ADDR_W-1:0] LO_BASE = 16'h5000,
  parameter logic [ADDR_W-1:0] HI_BASE = 16'h5800
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output cit_pkg::cit_acc_t acc
);
  localparam logic [ADDR_W-1:0] WIN_MASK = ~((ADDR_W'(1) << SPAN_BITS) - ADDR_W'(1));

  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] base);
    return ((a ^ base) & WIN_MASK) == '0;
  endfunction

  logic hit_lo, hit_hi;
  assign hit_lo = in_window(addr, LO_BASE);
  assign hit_hi = in_window(addr, HI_BASE);

  assign acc.rd_lo = rd & hit_lo;
  assign acc.rd_hi = rd & hit_hi;
  assign acc.wr_lo = wr & hit_lo;
  assign acc.wr_hi = wr & hit_hi;
endmodule

// File: rtl/cit_counter.sv
module cit_counter #(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2*DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt,
  output logic              irq_en,
  output logic              fire
);
  localparam int HI_W = CNT_W - DATA_W;
  localparam logic [CNT_W-1:0] CEIL     = '1;
  localparam logic [CNT_W-1:0] CEIL_M1  = {{(CNT_W-1){1'b1}}, 1'b0};

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CEIL) ? v : v + CNT_W'(1);
  endfunction

  logic bus_load;
  assign bus_load = wr_lo | wr_hi;
  // request event: the counting step that lands on the ceiling
  assign fire = tick & ~bus_load & irq_en & (cnt == CEIL_M1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      irq_en <= 1'b0;
    end else if (wr_lo) begin
      cnt[DATA_W-1:0] <= wdata;
    end else if (wr_hi) begin
      cnt[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
      irq_en              <= wdata[DATA_W-1];
    end else if (tick) begin
      cnt <= sat_inc(cnt);
    end
  end

  // R5: one step per tick below the ceiling
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !bus_load && cnt != CEIL) |=> cnt == CNT_W'($past(cnt) + CNT_W'(1)));
  // R6: ceiling holds
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_load && cnt == CEIL) |=> cnt == CEIL);
  // R9: low write wins over tick
  p_wr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> cnt[DATA_W-1:0] == $past(wdata));
  // R3: high write sets enable
  p_en_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> irq_en == $past(wdata[DATA_W-1]));
endmodule

// File: rtl/cit_irq.sv
module cit_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic ack,
  output logic irq
);
  // a new event outranks an acknowledge in the same clock
  always_ff @(posedge clk) begin
    if (!rst_n)    irq <= 1'b0;
    else if (fire) irq <= 1'b1;
    else if (ack)  irq <= 1'b0;
  end

  // R7: only an event raises the request
  p_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(fire));
  // R8: held until acknowledged
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack && !fire) |=> irq);
  // R8: acknowledge drops it
  p_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !fire) |=> !irq);
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int SPAN_BITS = 11,
  parameter logic [ADDR_W-1:0] LO_BASE = 16'h5000,
  parameter logic [ADDR_W-1:0] HI_BASE = 16'h5800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cyc_tick,
  output logic              irq
);
  localparam int CNT_W = 2*DATA_W - 1;

  cit_pkg::cit_acc_t acc;
  logic [CNT_W-1:0]  cnt;
  logic              irq_en;
  logic              fire;
  logic              ack;

  cit_decode #(.ADDR_W(ADDR_W), .SPAN_BITS(SPAN_BITS),
               .LO_BASE(LO_BASE), .HI_BASE(HI_BASE)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .acc(acc));

  cit_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(cyc_tick),
    .wr_lo(acc.wr_lo), .wr_hi(acc.wr_hi), .wdata(bus_wdata),
    .cnt(cnt), .irq_en(irq_en), .fire(fire));

  assign ack = cit_pkg::any_access(acc);

  cit_irq u_irq (.clk(clk), .rst_n(rst_n), .fire(fire), .ack(ack), .irq(irq));

  always_comb begin
    if (acc.rd_lo)      bus_rdata = cnt[DATA_W-1:0];
    else if (acc.rd_hi) bus_rdata = {irq_en, cnt[CNT_W-1:DATA_W]};
    else                bus_rdata = '0;
  end

  // R10: no window, no data
  p_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc.rd_lo || acc.rd_hi) |-> bus_rdata == '0);
  // R4: decoded windows never overlap
  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc.rd_lo, acc.rd_hi}));
endmodule

// File: tb/test_cyc_irq_timer.sv
module test_cyc_irq_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0, cyc_tick = 1'b0;
  logic [7:0]  bus_rdata;
  logic        irq;

  always #10 clk = ~clk; // 50 MHz

  cyc_irq_timer i_cyc_irq_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
    .cyc_tick(cyc_tick), .irq(irq));

  typedef struct {
    bit       on_irq;
    logic [7:0] exp;
    string    tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // monitor: compares each queued expectation against the ports
  initial begin
    forever begin
      wait (q.size() != 0);
      begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        act = it.on_irq ? {7'b0, irq} : bus_rdata;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic push(input bit on_irq, input logic [7:0] exp, input string tag);
    item_t it;
    it.on_irq = on_irq; it.exp = exp; it.tag = tag;
    q.push_back(it);
    #1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input bit tk = 1'b0);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; cyc_tick = tk;
    @(negedge clk);
    bus_wr = 1'b0; cyc_tick = 1'b0;
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    push(1'b0, exp, tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic irq_chk(input bit exp, input string tag);
    push(1'b1, {7'b0, exp}, tag);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    cyc_tick = 1'b1;
    repeat (n) @(negedge clk);
    cyc_tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    irq_chk(1'b0, "R1 irq after reset");
    rd_chk(16'h5000, 8'h00, "R1 low after reset");
    rd_chk(16'h5800, 8'h00, "R1 high after reset");

    wr(16'h5000, 8'h34);
    wr(16'h5FFF, 8'h12);
    rd_chk(16'h5000, 8'h34, "R2 low load");
    rd_chk(16'h5800, 8'h12, "R3 high load");
    wr(16'h57FF, 8'hAB);
    rd_chk(16'h5FFF, 8'h12, "R2 high kept");
    rd_chk(16'h5123, 8'hAB, "R4 low read mid window");
    wr(16'h5800, 8'h85);
    rd_chk(16'h5C00, 8'h85, "R3 enable bit");
    rd_chk(16'h5000, 8'hAB, "R3 low kept");

    wr(16'h5800, 8'h00);
    wr(16'h5000, 8'h10);
    ticks(5);
    rd_chk(16'h5000, 8'h15, "R5 five ticks");
    wr(16'h5800, 8'h01);
    wr(16'h5000, 8'hFE);
    ticks(3);
    rd_chk(16'h5000, 8'h01, "R5 carry low");
    rd_chk(16'h5800, 8'h02, "R5 carry high");

    wr(16'h5000, 8'h40, 1'b1);
    rd_chk(16'h5000, 8'h40, "R9 low write beats tick");
    wr(16'h5800, 8'h03, 1'b1);
    rd_chk(16'h5000, 8'h40, "R9 tick lost on high write");

    wr(16'h5000, 8'hFC);
    wr(16'h5800, 8'hFF);
    irq_chk(1'b0, "R7 below ceiling");
    ticks(2);
    irq_chk(1'b0, "R7 at 0x7FFE");
    ticks(1);
    irq_chk(1'b1, "R7 raised at ceiling");
    ticks(3);
    irq_chk(1'b1, "R8 held");
    rd_chk(16'h5000, 8'hFF, "R6 saturated low");
    irq_chk(1'b0, "R8 read ack");
    ticks(5);
    irq_chk(1'b0, "R11 no refire at ceiling");
    rd_chk(16'h5800, 8'hFF, "R6 saturated high");

    wr(16'h5000, 8'hFE);
    ticks(1);
    irq_chk(1'b1, "R7 raised again");
    wr(16'h5800, 8'hFF);
    irq_chk(1'b0, "R8 write ack");

    wr(16'h5800, 8'h7F);
    wr(16'h5000, 8'hFE);
    ticks(2);
    irq_chk(1'b0, "R7 disabled");
    rd_chk(16'h5000, 8'hFF, "R6 disabled still saturates");

    wr(16'h5800, 8'hFF);
    wr(16'h5000, 8'hFE);
    ticks(1);
    irq_chk(1'b1, "R7 setup for R10");
    wr(16'h6000, 8'h00);
    irq_chk(1'b1, "R10 outside write no ack");
    rd_chk(16'h6000, 8'h00, "R10 outside read data");
    irq_chk(1'b1, "R10 outside read no ack");
    wr(16'h4FFF, 8'h00);
    rd_chk(16'h5000, 8'hFF, "R10 outside write no load");
    irq_chk(1'b0, "R8 ack after outside tests");

    wait (q.size() == 0);
    #1;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule